// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits between an instruction-memory fetch stream and an execution pipeline. It takes 16-bit instruction words one at a time over a valid/ready input. It decides whether each instruction fills one word or two, and hands exactly one decoded instruction per transfer to a valid/ready output. Each decoded instruction carries these fields:

- the mode bit
- the 5-bit opcode
- the 5-bit destination register index
- a source-kind code
- a source register index
- a 16-bit operand
- the word address at which the instruction began

Back-pressure rules: a decoded instruction stays on the output, unchanged, until `out_ready` takes it. While it waits, `in_ready` stays low, so no fetch word is consumed. When the output is empty, or is being taken in the same cycle, a new word may be accepted. `in_ready` also drops during a flush cycle and during an address-load cycle. A flush discards a half-built two-word instruction and any output not yet taken. The word-address counter is loaded from `addr_start` and then steps once per accepted word.

Top module: `ifd_top`

## Requirements
- R1: Fields of the first word: bit 15 is the mode bit, bits 14..10 the opcode and bits 9..5 the destination index. These appear unchanged on `out_mode`, `out_opcode` and `out_dst`. Bits 4..0 form the source field.
- R2: With mode 0 and a source field other than 5'b11111, the instruction is one word long. The output shows `out_src_kind` = 2'd0 (register), `out_src_reg` = the source field and `out_operand` = 0.
- R3: With mode 1, the instruction is one word long. The output shows `out_src_kind` = 2'd1 (short immediate), `out_src_reg` = 0 and `out_operand` = the source field zero-extended to 16 bits.
- R4: With mode 0 and a source field of 5'b11111, the instruction is two words long. No output appears until the next word is accepted. The result then shows `out_src_kind` = 2'd2 (long immediate), `out_src_reg` = 0 and `out_operand` = that whole second word.
- R5: The output holds registered values. An instruction is presented with `out_valid` high in the cycle right after the clock edge that accepted its last word.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field stays stable.
- R7: A flush cycle forces `in_ready` low. After that edge, `out_valid` is low and any pending first word is dropped, so the next accepted word is decoded as a first word.
- R8: `out_addr` is the address of the instruction's first word. The counter advances by one per accepted word and wraps modulo 2^ADDR_W. An `addr_load` cycle sets the counter to `addr_start` and forces `in_ready` low.
- R9: After reset, `out_valid` is low, the decoder waits for a first word and the counter is 0.
- R10: A register-kind result never shows source index 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of partial and held instructions |
| addr_load | input | 1 | Load the word-address counter |
| addr_start | input | ADDR_W | Value loaded into the counter |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Decoder takes the fetch word this cycle |
| in_word | input | 16 | Fetch word |
| out_valid | output | 1 | Decoded instruction present |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| out_mode | output | 1 | Mode bit |
| out_opcode | output | 5 | Opcode |
| out_dst | output | 5 | Destination register index |
| out_src_kind | output | 2 | 0 register, 1 short immediate, 2 long immediate |
| out_src_reg | output | 5 | Source register index (0 for immediates) |
| out_operand | output | 16 | Immediate operand (0 for register sources) |
| out_addr | output | ADDR_W | Address of the first word |

## Verification
The assertions check these rules on every cycle:

- a held output stays stable and blocks input;
- a flush empties the output;
- an address load blocks input;
- kind and mode agree;
- a short immediate carries no upper bits;
- a register result never names index 31.

Other behaviours can only be shown by the bench's scenarios, compared cycle by cycle with a reference model:

- a long immediate is joined correctly across idle gaps;
- an instruction's address is its first word's address, including across a counter wrap;
- after a flush the next word starts a fresh instruction;
- the one-cycle latency from acceptance to output.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int IW       = 16;
  localparam int OPC_W    = 5;
  localparam int REG_W    = 5;
  localparam int SRC_LSB  = 0;
  localparam int DST_LSB  = SRC_LSB + REG_W;
  localparam int OPC_LSB  = DST_LSB + REG_W;
  localparam int MODE_BIT = OPC_LSB + OPC_W;
  localparam logic [REG_W-1:0] LONG_TAG = {REG_W{1'b1}};

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_SHORT = 2'd1,
    SRC_LONG  = 2'd2
  } src_kind_e;

  typedef struct packed {
    logic             mode;
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] dst;
    src_kind_e        kind;
    logic [REG_W-1:0] sreg;
    logic [IW-1:0]    operand;
  } dec_t;
endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split
  import ifd_pkg::*;
(
  input  logic [IW-1:0] word,
  output logic          is_long,
  output dec_t          dec
);
  logic [REG_W-1:0] src;
  logic             mode;

  assign src  = word[SRC_LSB +: REG_W];
  assign mode = word[MODE_BIT];

  always_comb begin
    dec.mode    = mode;
    dec.opc     = word[OPC_LSB +: OPC_W];
    dec.dst     = word[DST_LSB +: REG_W];
    is_long     = !mode && (src == LONG_TAG);
    dec.kind    = SRC_REG;
    dec.sreg    = '0;
    dec.operand = '0;
    if (mode) begin
      dec.kind    = SRC_SHORT;
      dec.operand = IW'(src);
    end else if (is_long) begin
      dec.kind    = SRC_LONG;
    end else begin
      dec.sreg    = src;
    end
  end
endmodule

// File: rtl/ifd_addr_ctr.sv
module ifd_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          step,
  output logic [AW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= start;
    else if (step) cnt <= cnt + AW'(1);
  end
endmodule

// File: rtl/ifd_assembler.sv
module ifd_assembler
  import ifd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          accept,
  input  logic [IW-1:0] word,
  input  logic          first_long,
  input  dec_t          first_dec,
  input  logic [AW-1:0] cur_addr,
  input  logic          out_ready,
  output logic          out_valid,
  output dec_t          out_dec,
  output logic [AW-1:0] out_addr
);
  typedef enum logic {ST_FIRST, ST_SECOND} asm_state_e;

  asm_state_e    state;
  dec_t          pend_dec;
  logic [AW-1:0] pend_addr;
  logic          emit;
  logic          start_pair;

  assign start_pair = accept && (state == ST_FIRST) && first_long;
  assign emit       = accept && !start_pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FIRST;
      out_valid <= 1'b0;
    end else if (flush) begin
      state     <= ST_FIRST;
      out_valid <= 1'b0;
    end else begin
      if (emit)                       out_valid <= 1'b1;
      else if (out_valid && out_ready) out_valid <= 1'b0;
      if (start_pair)                     state <= ST_SECOND;
      else if (accept && state == ST_SECOND) state <= ST_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (start_pair) begin
      pend_dec  <= first_dec;
      pend_addr <= cur_addr;
    end
    if (emit && !flush) begin
      if (state == ST_SECOND) begin
        out_dec         <= pend_dec;
        out_dec.operand <= word;
        out_addr        <= pend_addr;
      end else begin
        out_dec  <= first_dec;
        out_addr <= cur_addr;
      end
    end
  end
endmodule

// File: rtl/ifd_top.sv
module ifd_top
  import ifd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_mode,
  output logic [4:0]        out_opcode,
  output logic [4:0]        out_dst,
  output logic [1:0]        out_src_kind,
  output logic [4:0]        out_src_reg,
  output logic [15:0]       out_operand,
  output logic [ADDR_W-1:0] out_addr
);
  logic              accept;
  logic              first_long;
  dec_t              first_dec;
  dec_t              held_dec;
  logic [ADDR_W-1:0] cur_addr;

  assign in_ready = !flush && !addr_load && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  ifd_field_split u_split (
    .word    (in_word),
    .is_long (first_long),
    .dec     (first_dec)
  );

  ifd_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load),
    .start (addr_start),
    .step  (accept),
    .cnt   (cur_addr)
  );

  ifd_assembler #(.AW(ADDR_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .accept     (accept),
    .word       (in_word),
    .first_long (first_long),
    .first_dec  (first_dec),
    .cur_addr   (cur_addr),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_dec    (held_dec),
    .out_addr   (out_addr)
  );

  assign out_mode     = held_dec.mode;
  assign out_opcode   = held_dec.opc;
  assign out_dst      = held_dec.dst;
  assign out_src_kind = held_dec.kind;
  assign out_src_reg  = held_dec.sreg;
  assign out_operand  = held_dec.operand;
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          addr_load,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_mode,
  input logic [4:0]    out_opcode,
  input logic [4:0]    out_dst,
  input logic [1:0]    out_src_kind,
  input logic [4:0]    out_src_reg,
  input logic [15:0]   out_operand,
  input logic [AW-1:0] out_addr
);
  logic [AW+38:0] bundle;
  assign bundle = {out_mode, out_opcode, out_dst, out_src_kind, out_src_reg, out_operand, out_addr};

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(bundle)); // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R7
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> !in_ready); // R8
  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src_kind == 2'd1 |-> out_mode && out_operand[15:5] == 11'd0 && out_src_reg == 5'd0); // R3
  AST_WIDE_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src_kind != 2'd1 |-> !out_mode && out_src_kind != 2'd3); // R4
  AST_NO_REG31: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src_kind == 2'd0 |-> out_src_reg != 5'd31 && out_operand == 16'd0); // R10
  AST_ID_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_opcode, out_dst, out_addr})); // R1
endmodule

bind ifd_top ifd_checker #(.AW(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .addr_load    (addr_load),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_mode     (out_mode),
  .out_opcode   (out_opcode),
  .out_dst      (out_dst),
  .out_src_kind (out_src_kind),
  .out_src_reg  (out_src_reg),
  .out_operand  (out_operand),
  .out_addr     (out_addr)
);

// File: tb/ifd_top_bench.sv
module ifd_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, addr_load = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] addr_start = '0, in_word = '0;
  logic        in_ready, out_valid, out_mode;
  logic [4:0]  out_opcode, out_dst, out_src_reg;
  logic [1:0]  out_src_kind;
  logic [15:0] out_operand, out_addr;

  int n_chk = 0, n_fail = 0, cycles = 0;

  // reference model state
  bit        m_valid, m_pend;
  bit [15:0] m_word, m_second, m_addr, m_pw, m_paddr, m_cnt;

  always #5 clk = ~clk;

  ifd_top u_ifd_top (
    .clk(clk), .rst_n(rst_n), .flush(flush), .addr_load(addr_load), .addr_start(addr_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_mode(out_mode), .out_opcode(out_opcode), .out_dst(out_dst),
    .out_src_kind(out_src_kind), .out_src_reg(out_src_reg), .out_operand(out_operand),
    .out_addr(out_addr)
  );

  function automatic bit exp_ready();
    return !flush && !addr_load && (!m_valid || out_ready);
  endfunction

  // expected {mode,opc,dst,kind,sreg,operand,addr} from the requirements
  function automatic logic [54:0] exp_bundle();
    logic [4:0]  s = m_word[4:0];
    logic [1:0]  k;
    logic [4:0]  r = 5'd0;
    logic [15:0] op = 16'd0;
    if (m_word[15]) begin k = 2'd1; op = {11'd0, s}; end
    else if (s == 5'd31) begin k = 2'd2; op = m_second; end
    else begin k = 2'd0; r = s; end
    return {m_word[15], m_word[14:10], m_word[9:5], k, r, op, m_addr};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_valid = 0; m_pend = 0; m_cnt = 0;
    end else begin
      bit acc;
      acc = in_valid && exp_ready();
      if (flush) begin
        m_valid = 0; m_pend = 0;
      end else begin
        if (m_valid && out_ready) m_valid = 0;
        if (acc) begin
          if (m_pend) begin
            m_valid = 1; m_word = m_pw; m_second = in_word; m_addr = m_paddr; m_pend = 0;
          end else if (!in_word[15] && in_word[4:0] == 5'd31) begin
            m_pend = 1; m_pw = in_word; m_paddr = m_cnt;
          end else begin
            m_valid = 1; m_word = in_word; m_addr = m_cnt;
          end
        end
      end
      if (addr_load) m_cnt = addr_start;
      else if (acc)  m_cnt = m_cnt + 16'd1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] w, input bit ordy, input bit fl,
                      input bit ld, input logic [15:0] st, input string tag);
    logic [54:0] act;
    @(negedge clk);
    chk(out_valid === m_valid, tag, "out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      act = {out_mode, out_opcode, out_dst, out_src_kind, out_src_reg, out_operand, out_addr};
      chk(act === exp_bundle(), tag, "fields", 64'(act), 64'(exp_bundle()));
    end
    in_valid = v; in_word = w; out_ready = ordy; flush = fl; addr_load = ld; addr_start = st;
    #1;
    chk(in_ready === exp_ready(), tag, "in_ready", 64'(in_ready), 64'(exp_ready()));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", "reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    step(0, 16'h0, 1, 0, 0, 0, "R9");
    // R9: first instruction after reset reports address 0; R1 R2 register forms
    step(1, {1'b0, 5'd3, 5'd7, 5'd2}, 1, 0, 0, 0, "R2");
    step(1, {1'b0, 5'd31, 5'd30, 5'd30}, 1, 0, 0, 0, "R1");
    step(1, {1'b0, 5'd0, 5'd0, 5'd0}, 1, 0, 0, 0, "R5");
    // R3 short immediates
    step(1, {1'b1, 5'd9, 5'd4, 5'd31}, 1, 0, 0, 0, "R3");
    step(1, {1'b1, 5'd1, 5'd1, 5'd0}, 1, 0, 0, 0, "R3");
    // R4 long immediate with idle gap between words; R10
    step(1, {1'b0, 5'd5, 5'd6, 5'd31}, 1, 0, 0, 0, "R4");
    step(0, 16'h0, 1, 0, 0, 0, "R4");
    step(0, 16'h0, 1, 0, 0, 0, "R4");
    step(1, 16'hBEEF, 1, 0, 0, 0, "R10");
    step(0, 16'h0, 1, 0, 0, 0, "R4");
    // R6 back-pressure: output held, input blocked
    step(1, {1'b0, 5'd2, 5'd2, 5'd2}, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, {1'b1, 5'd3, 5'd3, 5'd3}, 0, 0, 0, 0, "R6");
    step(1, {1'b1, 5'd3, 5'd3, 5'd3}, 1, 0, 0, 0, "R6");
    step(0, 16'h0, 1, 0, 0, 0, "R6");
    // R7 flush drops pending first word
    step(1, {1'b0, 5'd4, 5'd4, 5'd31}, 1, 0, 0, 0, "R7");
    step(1, 16'h1234, 1, 1, 0, 0, "R7");
    step(1, {1'b0, 5'd6, 5'd1, 5'd1}, 1, 0, 0, 0, "R7");
    // R7 flush drops held output
    step(1, {1'b0, 5'd7, 5'd1, 5'd1}, 0, 0, 0, 0, "R7");
    step(0, 16'h0, 0, 1, 0, 0, "R7");
    step(0, 16'h0, 1, 0, 0, 0, "R7");
    // R8 load and wrap across a two-word instruction
    step(1, 16'h0, 1, 0, 1, 16'hFFFF, "R8");
    step(1, {1'b0, 5'd8, 5'd9, 5'd31}, 1, 0, 0, 0, "R8");
    step(1, 16'hA5A5, 1, 0, 0, 0, "R8");
    step(1, {1'b1, 5'd8, 5'd9, 5'd10}, 1, 0, 0, 0, "R8");
    step(0, 16'h0, 1, 0, 0, 0, "R8");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w = 16'($urandom);
      if ($urandom % 3 == 0) begin w[15] = 1'b0; w[4:0] = 5'd31; end
      step(($urandom % 4) != 0, w, ($urandom % 3) != 0, ($urandom % 60) == 0,
           ($urandom % 80) == 0, 16'($urandom), "R4");
    end
    step(0, 16'h0, 1, 0, 0, 0, "R5");
    finish_run();
  end
endmodule